// File: doc/BRIEF.md
# PCM Bit Clock Rate Detector

This block works out which PCM highway format a line card is running on. It counts the cycles of the PCM bit clock from one rising edge of the 8 kHz frame sync to the next. It then sorts the count into one of four highway classes: 24, 32, 64 or 128 time slots per frame. These classes match bit clocks of 1.536/1.544 MHz, 2.048 MHz, 4.096 MHz and 8.192 MHz.

The block reports a 2-bit format code, the matching slot count and a locked flag. The time-slot logic downstream uses the slot count as the upper bound of its slot counter. It should trust that bound only while the locked flag is set.

Detection runs only while both the bit clock and the frame sync are present. A missing frame sync lets the period counter saturate, and saturation drops the lock.

Top module: `pcm_rate_detect`

## Requirements
- R1: While reset is asserted, and right after it, `locked` is 0, `fmt_code` is 1 and `slot_count` is 32.
- R2: The frame period is the number of bit-clock cycles between two consecutive rising edges of `fsync`. A frame sync held high for many cycles counts as one edge. The first rising edge after reset or after saturation only starts a measurement.
- R3: A period of 256 selects code 1 (32 slots), 512 selects code 2 (64 slots) and 1024 selects code 3 (128 slots). `slot_count` always shows the slot number of the current code.
- R4: Lock is declared only after two consecutive measured periods fall into the same class. `fmt_code` takes that class on the same clock edge that samples the second rising edge.
- R5: `fmt_code` changes only on an edge where `locked` goes from 0 to 1.
- R6: A period that matches no class clears `locked`, leaves `fmt_code` unchanged and restarts the two-frame lock count.
- R7: While locked, a single valid period of another class is tolerated. A matching period in between clears that tally. A second consecutive mismatching period drops lock, and that class can then lock on its next repeat.
- R8: The period counter saturates at 2047. An edge where the counter is at 2047 and no rising edge of `fsync` is seen clears `locked`, and the next rising edge only re-arms the measurement.
- R9: Periods of 192 and 193 both select code 0 (24 slots), so frames of either length count toward the same lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync, short or long pulse, 8 kHz |
| fmt_code | output | 2 | Highway class: 0=24, 1=32, 2=64, 3=128 slots |
| slot_count | output | 8 | Time slots per frame for the current class |
| locked | output | 1 | Format confirmed by repeated frames |

## Verification
The bench drives frame-sync trains whose lengths change from one train to the next. Because of this, the period measured at each rising edge is the length of the train before it. The expected model follows the actual edge spacing. A design that measured the new spacing instead of the elapsed one would report its class one frame early.

The bench targets these corner cases:
- Single mismatches while locked, and a matching frame between two mismatches. A design that dropped lock on the first mismatch would lose lock on one odd frame. A design that never cleared the tally would drop lock on two mismatches that are not adjacent.
- A mix of 192 and 193 cycle frames. A design that treated these as different classes would never lock onto the 24-slot format.
- An invalid count. A design that updated the format on that count would change `fmt_code` while unlocked.
- Long frame-sync pulses. A design that counted levels instead of edges would measure nonsense.
- A gap longer than 2047 cycles. A design without saturation would wrap its counter and keep a stale lock.

// File: rtl/pcm_rd_pkg.sv
package pcm_rd_pkg;

   typedef enum logic [1:0] {
      HWY_24  = 2'd0,
      HWY_32  = 2'd1,
      HWY_64  = 2'd2,
      HWY_128 = 2'd3
   } hwy_fmt_e;

   // slots per frame for each highway class
   function automatic int unsigned slots_of(hwy_fmt_e f);
      case (f)
         HWY_24:  return 24;
         HWY_32:  return 32;
         HWY_64:  return 64;
         default: return 128;
      endcase
   endfunction

endpackage

// File: rtl/pcm_rd_period.sv
module pcm_rd_period #(
   parameter int CNT_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync,
   output logic             stb,
   output logic             sat,
   output logic [CNT_W-1:0] period
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             fs_q;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_q <= 1'b0;
      else        fs_q <= fsync;
   end

   assign stb = fsync & ~fs_q;
   assign sat = (cnt == CNT_MAX) & ~stb;

   // cnt equals the elapsed period on the edge that sees the next rise
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (stb)            cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
   end

   assign period = cnt;
endmodule

// File: rtl/pcm_rd_classify.sv
module pcm_rd_classify
   import pcm_rd_pkg::*;
#(
   parameter int CNT_W         = 11,
   parameter int BITS_PER_SLOT = 8,
   parameter bit ACCEPT_FBIT   = 1'b1
) (
   input  logic [CNT_W-1:0] period,
   output logic             valid,
   output hwy_fmt_e         cls
);
   localparam logic [CNT_W-1:0] LEN_24  = CNT_W'(24  * BITS_PER_SLOT);
   localparam logic [CNT_W-1:0] LEN_32  = CNT_W'(32  * BITS_PER_SLOT);
   localparam logic [CNT_W-1:0] LEN_64  = CNT_W'(64  * BITS_PER_SLOT);
   localparam logic [CNT_W-1:0] LEN_128 = CNT_W'(128 * BITS_PER_SLOT);

   logic is_24;

   generate
      if (ACCEPT_FBIT) begin : g_fbit
         // a framing bit stretches the 24-slot frame by one clock
         assign is_24 = (period == LEN_24) || (period == LEN_24 + 1'b1);
      end else begin : g_plain
         assign is_24 = (period == LEN_24);
      end
   endgenerate

   always_comb begin
      valid = 1'b1;
      cls   = HWY_32;
      if (is_24)                  cls = HWY_24;
      else if (period == LEN_32)  cls = HWY_32;
      else if (period == LEN_64)  cls = HWY_64;
      else if (period == LEN_128) cls = HWY_128;
      else                        valid = 1'b0;
   end
endmodule

// File: rtl/pcm_rd_lock.sv
module pcm_rd_lock
   import pcm_rd_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     stb,
   input  logic     sat,
   input  logic     valid,
   input  hwy_fmt_e cls,
   output logic     locked,
   output hwy_fmt_e fmt
);
   logic     armed;
   logic     prev_ok;
   logic     miss;
   hwy_fmt_e prev_cls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed    <= 1'b0;
         prev_ok  <= 1'b0;
         miss     <= 1'b0;
         prev_cls <= HWY_32;
         locked   <= 1'b0;
         fmt      <= HWY_32;
      end else if (stb) begin
         if (!armed) begin
            armed <= 1'b1;
         end else if (!valid) begin
            locked  <= 1'b0;
            prev_ok <= 1'b0;
            miss    <= 1'b0;
         end else begin
            prev_cls <= cls;
            prev_ok  <= 1'b1;
            if (!locked) begin
               if (prev_ok && (prev_cls == cls)) begin
                  locked <= 1'b1;
                  fmt    <= cls;
                  miss   <= 1'b0;
               end
            end else if (cls == fmt) begin
               miss <= 1'b0;
            end else if (miss) begin
               locked <= 1'b0;
               miss   <= 1'b0;
            end else begin
               miss <= 1'b1;
            end
         end
      end else if (sat) begin
         locked  <= 1'b0;
         armed   <= 1'b0;
         prev_ok <= 1'b0;
         miss    <= 1'b0;
      end
   end
endmodule

// File: rtl/pcm_rate_detect.sv
module pcm_rate_detect
   import pcm_rd_pkg::*;
#(
   parameter int BITS_PER_SLOT = 8,
   parameter int CNT_W         = 11,
   parameter int SLOT_W        = 8,
   parameter bit ACCEPT_FBIT   = 1'b1
) (
   input  logic              bclk,
   input  logic              rst_n,
   input  logic              fsync,
   output logic [1:0]        fmt_code,
   output logic [SLOT_W-1:0] slot_count,
   output logic              locked
);
   localparam int LONGEST = 128 * BITS_PER_SLOT;

   generate
      if ((2 ** CNT_W) - 1 <= LONGEST + 1) begin : g_bad_cnt
         $error("CNT_W too narrow for the longest frame");
      end
      if (SLOT_W < 8) begin : g_bad_slot
         $error("SLOT_W cannot hold 128");
      end
      if (BITS_PER_SLOT < 1) begin : g_bad_bits
         $error("BITS_PER_SLOT must be positive");
      end
   endgenerate

   logic             meas_stb;
   logic             cnt_sat;
   logic [CNT_W-1:0] period_cnt;
   logic             cls_valid;
   hwy_fmt_e         cls_now;
   hwy_fmt_e         fmt_q;

   pcm_rd_period #(.CNT_W(CNT_W)) u_period (
      .clk    (bclk),
      .rst_n  (rst_n),
      .fsync  (fsync),
      .stb    (meas_stb),
      .sat    (cnt_sat),
      .period (period_cnt)
   );

   pcm_rd_classify #(
      .CNT_W         (CNT_W),
      .BITS_PER_SLOT (BITS_PER_SLOT),
      .ACCEPT_FBIT   (ACCEPT_FBIT)
   ) u_classify (
      .period (period_cnt),
      .valid  (cls_valid),
      .cls    (cls_now)
   );

   pcm_rd_lock u_lock (
      .clk    (bclk),
      .rst_n  (rst_n),
      .stb    (meas_stb),
      .sat    (cnt_sat),
      .valid  (cls_valid),
      .cls    (cls_now),
      .locked (locked),
      .fmt    (fmt_q)
   );

   assign fmt_code   = fmt_q;
   assign slot_count = SLOT_W'(slots_of(fmt_q));
endmodule

// File: rtl/pcm_rate_detect_chk.sv
module pcm_rate_detect_chk #(
   parameter int CNT_W = 11
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stb,
   input logic             sat,
   input logic             valid,
   input logic             locked,
   input logic [1:0]       fmt,
   input logic [CNT_W-1:0] period
);
   AST_LOCK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(stb)); // R4

   AST_FMT_ONLY_AT_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fmt) |-> $rose(locked)); // R5

   AST_INVALID_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !valid) |=> !locked); // R6

   AST_UNLOCK_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> ($past(stb) || $past(sat))); // R7

   AST_SAT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      sat |=> !locked); // R8

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      sat |=> (period == '1)); // R8
endmodule

bind pcm_rate_detect pcm_rate_detect_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (bclk),
   .rst_n  (rst_n),
   .stb    (meas_stb),
   .sat    (cnt_sat),
   .valid  (cls_valid),
   .locked (locked),
   .fmt    (fmt_code),
   .period (period_cnt)
);

// File: tb/pcm_rate_detect_bench.sv
module pcm_rate_detect_bench;
   logic       bclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic [1:0] fmt_code;
   logic [7:0] slot_count;
   logic       locked;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #2 bclk = ~bclk;
   always @(posedge bclk) cyc <= cyc + 1;

   pcm_rate_detect u_pcm_rate_detect (
      .bclk       (bclk),
      .rst_n      (rst_n),
      .fsync      (fsync),
      .fmt_code   (fmt_code),
      .slot_count (slot_count),
      .locked     (locked)
   );

   // reference state from the requirements
   bit armed = 0, prev_ok = 0, miss = 0, r_locked = 0;
   int prev_cls = 1, r_fmt = 1, last_e = 0;

   // scoreboard queue
   int    q_due[$];
   bit    q_lk[$];
   int    q_fmt[$];
   string q_tag[$];

   function automatic int slots_for(int f);
      case (f)
         0: return 24;
         1: return 32;
         2: return 64;
         default: return 128;
      endcase
   endfunction

   task automatic compare(bit lk, int f, string tag);
      checks++;
      if (locked !== lk || fmt_code !== 2'(f) || slot_count !== 8'(slots_for(f))) begin
         fails++;
         $display("FAIL %s: got locked=%0b fmt=%0d slots=%0d, expected locked=%0b fmt=%0d slots=%0d",
                  tag, locked, fmt_code, slot_count, lk, f, slots_for(f));
      end
   endtask

   function automatic void sat_clear();
      r_locked = 0; armed = 0; prev_ok = 0; miss = 0;
   endfunction

   function automatic void model_rise(int p);
      bit v;
      int c;
      if (p >= 2048) sat_clear();                 // R8
      if (!armed) begin armed = 1; return; end
      v = 1;
      if (p == 192 || p == 193) c = 0;            // R9
      else if (p == 256) c = 1;
      else if (p == 512) c = 2;
      else if (p == 1024) c = 3;
      else begin v = 0; c = 0; end
      if (!v) begin
         r_locked = 0; prev_ok = 0; miss = 0;     // R6
      end else if (!r_locked) begin
         if (prev_ok && prev_cls == c) begin r_locked = 1; r_fmt = c; miss = 0; end
         prev_cls = c; prev_ok = 1;
      end else begin
         if (c == r_fmt) miss = 0;
         else if (miss) begin r_locked = 0; miss = 0; end
         else miss = 1;
         prev_cls = c; prev_ok = 1;
      end
   endfunction

   function automatic void push(int due, string tag);
      q_due.push_back(due); q_lk.push_back(r_locked);
      q_fmt.push_back(r_fmt); q_tag.push_back(tag);
   endfunction

   // driver: n frame-sync rises spaced by period, pulse high for width cycles
   task automatic frames(int period, int n, int width, string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge bclk);
         fsync = 1'b1;
         model_rise(cyc + 1 - last_e);
         last_e = cyc + 1;
         push(cyc + 1, tag);
         for (int j = 1; j < period; j++) begin
            @(negedge bclk);
            if (j == width) fsync = 1'b0;
            if (j == 2060) begin
               sat_clear();
               push(cyc + 1, "R8 saturation drops lock");
            end
         end
      end
   endtask

   // monitor
   initial begin
      forever begin
         @(negedge bclk);
         #1;
         while (q_due.size() > 0 && q_due[0] == cyc) begin
            compare(q_lk[0], q_fmt[0], q_tag[0]);
            void'(q_due.pop_front()); void'(q_lk.pop_front());
            void'(q_fmt.pop_front()); void'(q_tag.pop_front());
         end
      end
   end

   task automatic run();
      repeat (3) @(negedge bclk);
      compare(1'b0, 1, "R1 during reset");
      rst_n = 1'b1;
      @(negedge bclk);
      #1 compare(1'b0, 1, "R1 after reset");
      frames(256, 3, 1, "R4 lock on 32 slots");
      frames(193, 1, 1, "R7 first mismatch");
      frames(256, 1, 1, "R7 mismatch tolerated");
      frames(193, 2, 1, "R7 tally cleared then mismatch");
      frames(192, 2, 1, "R7 second mismatch drops lock");
      frames(193, 2, 1, "R9 192/193 lock 24 slots");
      frames(512, 4, 40, "R2 long sync, R3 64 slots");
      frames(300, 1, 1, "R3 64 slots still locked");
      frames(1024, 1, 1, "R6 invalid count unlocks, fmt kept");
      frames(1024, 3, 1, "R3 128 slots lock, R5");
      frames(2600, 1, 1, "R8 gap beyond saturation");
      frames(256, 4, 1, "R8 re-arm and relock");
      @(negedge bclk);
      fsync = 1'b1;
      model_rise(cyc + 1 - last_e);
      push(cyc + 1, "R3 final frame");
      repeat (4) @(negedge bclk);
      fsync = 1'b0;
      repeat (4) @(negedge bclk);
   endtask

   initial begin
      fork
         run();
         begin
            repeat (200000) @(posedge bclk);
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      if (q_due.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d pending, expected 0", q_due.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule